// File: doc/BRIEF.md
# Pad function multiplexer with merged peripheral inputs

This block sits between a ring of I/O pads and the on-chip peripherals. Software programs a function code for every pad through a small register write port. Code 0 makes the pad a general-purpose port bit, with its own direction and data bits. The other defined codes attach the pad to a peripheral input or output. Several pads may carry the same function at once. When they do, the peripheral input sees a logical merge of all of those pads. That merge is an OR for serial clock and receive data, and an AND for active-low request and enable style inputs. For an output function, every pad that selects it drives the same value.

A strap input marks single-chip operation. In that mode the external-bus functions are held at safe levels: address pads drive a fixed level, data pads float, and bus control outputs drive high. The bus-request and wait inputs toward the core are also forced inactive in that mode. All routing is combinational from the registered selects, so a pad-to-peripheral path adds no clock cycle.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset every pad select is 0, every direction bit is 0 and every data bit is 0, so `pad_oe` is all zero. A register write is visible at the outputs from the clock edge that captures it. Register addresses: 0 to NUM_PADS-1 hold the pad select codes, NUM_PADS holds the direction bits (1 means output), and NUM_PADS+1 holds the port data bits.
- R2: For a pad with select code 0, `pad_oe` equals its direction bit and `pad_out` equals its data bit. The matching `port_rd` bit returns the data bit when the direction bit is 1, and the pad input level otherwise.
- R3: Codes 1 and 2 route a pad to input functions 0 (serial clock) and 1 (serial receive data). Each of these functions is the OR of the inputs of all pads that select it.
- R4: Codes 3, 4, 5 and 6 route a pad to input functions 2 (interrupt request 0), 3 (interrupt request 1), 4 (external wait) and 5 (bus request). Each of these functions is the AND of the inputs of all pads that select it.
- R5: An OR-merged input function with no selecting pad reads 0. An AND-merged input function with no selecting pad reads 1.
- R6: Code 7 drives output function 0 (transmit data). Every pad with this code has `pad_oe` at 1 and `pad_out` equal to `fn_out[0]`.
- R7: Codes 8 to 11 are bus functions: address (`fn_out[1]`), data (`fn_out[2]`, enabled by `data_oe`), clock out (`fn_out[3]`) and bus acknowledge (`fn_out[4]`). When `single_chip` is 0 they drive the peripheral values. When it is 1, address pads drive ADDR_IDLE, data pads have `pad_oe` at 0, and clock-out and acknowledge pads drive 1.
- R8: While `single_chip` is 1, `fn_in[4]` and `fn_in[5]` read 1 (inactive), whatever the pads show.
- R9: Codes 12 to 15 act as a port input. The pad never drives, the code takes part in no merge, and `port_rd` returns the pad level whatever the direction bit holds.
- R10: Take a pad held low as a port input, with no pad selecting interrupt request 0. When its select is rewritten to code 3, `fn_in[2]` falls from 1 to 0 at that clock edge, so a downstream edge detector registers an edge.
- R11: `fn_in` follows a change of `pad_in` in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | WR_W | Register write data |
| single_chip | input | 1 | Single-chip mode strap |
| pad_in | input | NUM_PADS | Levels seen at the pads |
| pad_out | output | NUM_PADS | Values driven toward the pads |
| pad_oe | output | NUM_PADS | Pad output enables |
| port_rd | output | NUM_PADS | Port read value |
| fn_out | input | 5 | Peripheral output functions |
| data_oe | input | 1 | Output enable of the data bus function |
| fn_in | output | 6 | Merged peripheral input functions |

## Verification
A corrupted select register shows up at the ports in the cycle after the write that caused it. The wrong pad starts to drive, or an input function changes its merged level. Because merging is combinational, a fault in the merge or in the single-chip overrides shows in the same cycle as the pad or strap change that exposes it. The reference model is compared against every output on every clock, so a wrong state is reported within one cycle of the first stimulus that makes it visible.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   // pad function codes (the low codes of input functions map to fn_in index code-1)
   typedef enum logic [3:0] {
      FN_GPIO = 4'd0,
      FN_SCLK = 4'd1,
      FN_SRXD = 4'd2,
      FN_IRQ0 = 4'd3,
      FN_IRQ1 = 4'd4,
      FN_WAIT = 4'd5,
      FN_BREQ = 4'd6,
      FN_TXD  = 4'd7,
      FN_ADDR = 4'd8,
      FN_DATA = 4'd9,
      FN_CLKO = 4'd10,
      FN_BACK = 4'd11
   } fn_code_e;

   localparam int N_IN_FN  = 6;
   localparam int N_OUT_FN = 5;
   localparam int IN_BASE  = 1;

   // input function indices
   localparam int IN_SCLK = 0;
   localparam int IN_SRXD = 1;
   localparam int IN_IRQ0 = 2;
   localparam int IN_IRQ1 = 3;
   localparam int IN_WAIT = 4;
   localparam int IN_BREQ = 5;

   // output function indices
   localparam int OUT_TXD  = 0;
   localparam int OUT_ADDR = 1;
   localparam int OUT_DATA = 2;
   localparam int OUT_CLKO = 3;
   localparam int OUT_BACK = 4;

   // bit set: AND merge with idle level 1; bit clear: OR merge with idle level 0
   localparam logic [N_IN_FN-1:0] IN_AND_MASK = 6'b111100;
   // bit set: forced inactive in single-chip mode
   localparam logic [N_IN_FN-1:0] IN_BUS_MASK = 6'b110000;

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs #(
   parameter int NUM_PADS = 8,
   parameter int SEL_W    = 4,
   parameter int ADDR_W   = 4,
   parameter int WR_W     = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [WR_W-1:0]                 wr_data,
   output logic [NUM_PADS-1:0][SEL_W-1:0]  sel_q,
   output logic [NUM_PADS-1:0]             dir_q,
   output logic [NUM_PADS-1:0]             port_q
);

   localparam int DIR_ADDR  = NUM_PADS;
   localparam int PORT_ADDR = NUM_PADS + 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         dir_q  <= '0;
         port_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_PADS; i++) begin
            if (wr_addr == ADDR_W'(i))
               sel_q[i] <= wr_data[SEL_W-1:0];
         end
         if (wr_addr == ADDR_W'(DIR_ADDR))
            dir_q <= wr_data[NUM_PADS-1:0];
         if (wr_addr == ADDR_W'(PORT_ADDR))
            port_q <= wr_data[NUM_PADS-1:0];
      end
   end

endmodule

// File: rtl/pinmux_in_merge.sv
module pinmux_in_merge
   import pinmux_pkg::*;
#(
   parameter int NUM_PADS = 8,
   parameter int SEL_W    = 4
) (
   input  logic [NUM_PADS-1:0][SEL_W-1:0] sel_q,
   input  logic [NUM_PADS-1:0]            pad_in,
   input  logic                           single_chip,
   output logic [N_IN_FN-1:0]             fn_in
);

   for (genvar f = 0; f < N_IN_FN; f++) begin : g_fn
      logic [NUM_PADS-1:0] hit;
      logic                merged;

      always_comb begin
         for (int p = 0; p < NUM_PADS; p++)
            hit[p] = (sel_q[p] == SEL_W'(f + IN_BASE));
      end

      if (IN_AND_MASK[f]) begin : g_and
         assign merged = &(pad_in | ~hit);
      end else begin : g_or
         assign merged = |(pad_in & hit);
      end

      if (IN_BUS_MASK[f]) begin : g_bus
         assign fn_in[f] = merged | single_chip;
      end else begin : g_plain
         assign fn_in[f] = merged;
      end
   end

endmodule

// File: rtl/pinmux_pad_cell.sv
module pinmux_pad_cell
   import pinmux_pkg::*;
#(
   parameter int SEL_W     = 4,
   parameter bit ADDR_IDLE = 1'b0
) (
   input  logic [SEL_W-1:0]    sel,
   input  logic                dir_bit,
   input  logic                port_bit,
   input  logic                pad_in_bit,
   input  logic [N_OUT_FN-1:0] fn_out,
   input  logic                data_oe,
   input  logic                single_chip,
   output logic                out,
   output logic                oe,
   output logic                rd
);

   always_comb begin
      out = 1'b0;
      oe  = 1'b0;
      rd  = pad_in_bit;
      case (sel)
         SEL_W'(FN_GPIO): begin
            oe  = dir_bit;
            out = port_bit;
            if (dir_bit) rd = port_bit;
         end
         SEL_W'(FN_TXD): begin
            oe  = 1'b1;
            out = fn_out[OUT_TXD];
         end
         SEL_W'(FN_ADDR): begin
            oe  = 1'b1;
            out = single_chip ? ADDR_IDLE : fn_out[OUT_ADDR];
         end
         SEL_W'(FN_DATA): begin
            oe  = data_oe & ~single_chip;
            out = fn_out[OUT_DATA];
         end
         SEL_W'(FN_CLKO): begin
            oe  = 1'b1;
            out = single_chip | fn_out[OUT_CLKO];
         end
         SEL_W'(FN_BACK): begin
            oe  = 1'b1;
            out = single_chip | fn_out[OUT_BACK];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
   import pinmux_pkg::*;
#(
   parameter  int NUM_PADS  = 8,
   parameter  int SEL_W     = 4,
   parameter  bit ADDR_IDLE = 1'b0,
   localparam int ADDR_W    = $clog2(NUM_PADS + 2),
   localparam int WR_W      = (NUM_PADS > SEL_W) ? NUM_PADS : SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [WR_W-1:0]     wr_data,
   input  logic                single_chip,
   input  logic [NUM_PADS-1:0] pad_in,
   output logic [NUM_PADS-1:0] pad_out,
   output logic [NUM_PADS-1:0] pad_oe,
   output logic [NUM_PADS-1:0] port_rd,
   input  logic [N_OUT_FN-1:0] fn_out,
   input  logic                data_oe,
   output logic [N_IN_FN-1:0]  fn_in
);

   if (NUM_PADS < 2 || NUM_PADS > 64) begin : g_bad_pads
      $error("pinmux_ctrl: NUM_PADS must lie in 2..64");
   end
   if (SEL_W < 4) begin : g_bad_sel
      $error("pinmux_ctrl: SEL_W must hold every function code");
   end

   logic [NUM_PADS-1:0][SEL_W-1:0] sel_q;
   logic [NUM_PADS-1:0]            dir_q;
   logic [NUM_PADS-1:0]            port_q;

   pinmux_regs #(
      .NUM_PADS (NUM_PADS),
      .SEL_W    (SEL_W),
      .ADDR_W   (ADDR_W),
      .WR_W     (WR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sel_q   (sel_q),
      .dir_q   (dir_q),
      .port_q  (port_q)
   );

   pinmux_in_merge #(
      .NUM_PADS (NUM_PADS),
      .SEL_W    (SEL_W)
   ) u_merge (
      .sel_q       (sel_q),
      .pad_in      (pad_in),
      .single_chip (single_chip),
      .fn_in       (fn_in)
   );

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      pinmux_pad_cell #(
         .SEL_W     (SEL_W),
         .ADDR_IDLE (ADDR_IDLE)
      ) u_cell (
         .sel         (sel_q[p]),
         .dir_bit     (dir_q[p]),
         .port_bit    (port_q[p]),
         .pad_in_bit  (pad_in[p]),
         .fn_out      (fn_out),
         .data_oe     (data_oe),
         .single_chip (single_chip),
         .out         (pad_out[p]),
         .oe          (pad_oe[p]),
         .rd          (port_rd[p])
      );
   end

endmodule

// File: rtl/pinmux_ctrl_chk.sv
module pinmux_ctrl_chk
   import pinmux_pkg::*;
#(
   parameter int NUM_PADS = 8,
   parameter int SEL_W    = 4,
   parameter int ADDR_W   = 4,
   parameter int WR_W     = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [ADDR_W-1:0]              wr_addr,
   input logic [WR_W-1:0]                wr_data,
   input logic                           single_chip,
   input logic [NUM_PADS-1:0]            pad_out,
   input logic [NUM_PADS-1:0]            pad_oe,
   input logic [N_OUT_FN-1:0]            fn_out,
   input logic [N_IN_FN-1:0]             fn_in,
   input logic [NUM_PADS-1:0][SEL_W-1:0] sel_q,
   input logic [NUM_PADS-1:0]            dir_q
);

   logic irq0_used;
   logic sclk_used;

   always_comb begin
      irq0_used = 1'b0;
      sclk_used = 1'b0;
      for (int p = 0; p < NUM_PADS; p++) begin
         if (sel_q[p] == SEL_W'(FN_IRQ0)) irq0_used = 1'b1;
         if (sel_q[p] == SEL_W'(FN_SCLK)) sclk_used = 1'b1;
      end
   end

   // R1
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(NUM_PADS)) |=> dir_q == $past(wr_data[NUM_PADS-1:0]));

   // R5
   and_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq0_used |-> fn_in[IN_IRQ0]);

   // R5
   or_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_used |-> !fn_in[IN_SCLK]);

   // R8
   bus_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      single_chip |-> (fn_in[IN_WAIT] && fn_in[IN_BREQ]));

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad_chk
      // R6
      txd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q[i] == SEL_W'(FN_TXD)) |-> (pad_oe[i] && pad_out[i] == fn_out[OUT_TXD]));

      // R7
      data_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (single_chip && sel_q[i] == SEL_W'(FN_DATA)) |-> !pad_oe[i]);

      // R9
      undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q[i] > SEL_W'(FN_BACK)) |-> !pad_oe[i]);
   end

endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(
   .NUM_PADS (NUM_PADS),
   .SEL_W    (SEL_W),
   .ADDR_W   (ADDR_W),
   .WR_W     (WR_W)
) u_chk (.*);

// File: tb/pinmux_ctrl_bench.sv
`timescale 1ns/1ps
module pinmux_ctrl_bench;

   localparam int NP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       single_chip = 1'b0;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_out, pad_oe, port_rd;
   logic [4:0] fn_out = '0;
   logic       data_oe = 1'b0;
   logic [5:0] fn_in;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_en = 1'b0;
   string cur_req = "R1";

   // reference model state
   int         m_sel [NP];
   logic [7:0] m_dir = '0;
   logic [7:0] m_port = '0;
   logic [7:0] e_out, e_oe, e_rd;
   logic [5:0] e_fn;
   logic       irq0_d = 1'b1;

   always #4 clk = ~clk;

   pinmux_ctrl u_pinmux_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .single_chip(single_chip), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .port_rd(port_rd), .fn_out(fn_out), .data_oe(data_oe), .fn_in(fn_in)
   );

   always @(posedge clk) irq0_d <= fn_in[2];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_eval();
      e_oe = '0; e_out = '0; e_rd = pad_in; e_fn = 6'b111100;
      for (int p = 0; p < NP; p++) begin
         case (m_sel[p])
            0: begin
               e_oe[p] = m_dir[p]; e_out[p] = m_port[p];
               if (m_dir[p]) e_rd[p] = m_port[p];
            end
            1, 2: e_fn[m_sel[p]-1] = e_fn[m_sel[p]-1] | pad_in[p];
            3, 4, 5, 6: e_fn[m_sel[p]-1] = e_fn[m_sel[p]-1] & pad_in[p];
            7: begin e_oe[p] = 1; e_out[p] = fn_out[0]; end
            8: begin e_oe[p] = 1; e_out[p] = single_chip ? 1'b0 : fn_out[1]; end
            9: begin e_oe[p] = single_chip ? 1'b0 : data_oe; e_out[p] = fn_out[2]; end
            10: begin e_oe[p] = 1; e_out[p] = single_chip ? 1'b1 : fn_out[3]; end
            11: begin e_oe[p] = 1; e_out[p] = single_chip ? 1'b1 : fn_out[4]; end
            default: ;
         endcase
      end
      if (single_chip) e_fn[5:4] = 2'b11;
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_en) begin
         model_eval();
         chk({cur_req, " oe"}, 32'(pad_oe), 32'(e_oe));
         chk({cur_req, " out"}, 32'(pad_out & e_oe), 32'(e_out & e_oe));
         chk({cur_req, " rd"}, 32'(port_rd), 32'(e_rd));
         chk({cur_req, " fn"}, 32'(fn_in), 32'(e_fn));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(posedge clk); #1;
      wr_en = 1'b0;
      if (a < NP) m_sel[a] = d & 15;
      else if (a == NP) m_dir = 8'(d);
      else if (a == NP + 1) m_port = 8'(d);
   endtask

   task automatic at_neg();
      @(negedge clk); #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) m_sel[p] = 0;
      pad_in = 8'hFF;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset oe", 32'(pad_oe), 0);
      chk("R5 reset defaults", 32'(fn_in), 32'h3C);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // port mode
      cur_req = "R2";
      wr(8, 8'h0F);
      chk("R1 dir visible after edge", 32'(pad_oe), 32'h0F);
      wr(9, 8'h05);
      pad_in = 8'h3C;
      at_neg();
      chk("R2 port out", 32'(pad_out & 8'h0F), 32'h05);
      chk("R2 port read", 32'(port_rd), 32'h35);
      wr(8, 0);

      // OR merge
      cur_req = "R3";
      wr(0, 1); wr(1, 1); wr(2, 2);
      for (int v = 0; v < 4; v++) begin
         pad_in = 8'(v);
         at_neg();
         chk("R3 sclk OR", 32'(fn_in[0]), 32'(v != 0));
         chk("R3 srxd idle", 32'(fn_in[1]), 0);
      end
      pad_in[2] = 1'b1;
      at_neg();
      chk("R3 srxd", 32'(fn_in[1]), 1);

      // same-cycle propagation
      pad_in = 8'h00;
      #1;
      chk("R11 comb fall", 32'(fn_in[0]), 0);
      pad_in[1] = 1'b1;
      #1;
      chk("R11 comb rise", 32'(fn_in[0]), 1);

      // AND merge
      cur_req = "R4";
      wr(3, 4); wr(4, 4);
      for (int v = 0; v < 4; v++) begin
         pad_in[4:3] = 2'(v);
         at_neg();
         chk("R4 irq1 AND", 32'(fn_in[3]), 32'(v == 3));
      end

      // port to interrupt request with pad low
      cur_req = "R10";
      pad_in[5] = 1'b0;
      at_neg();
      chk("R5 irq0 empty", 32'(fn_in[2]), 1);
      wr(5, 3);
      at_neg();
      chk("R10 irq0 edge", 32'({irq0_d, fn_in[2]}), 32'b10);
      wr(5, 0);
      at_neg();
      chk("R5 irq0 released", 32'(fn_in[2]), 1);

      // shared output
      cur_req = "R6";
      wr(6, 7); wr(7, 7);
      fn_out[0] = 1'b1;
      at_neg();
      chk("R6 txd high", 32'({pad_oe[7:6], pad_out[7:6]}), 32'hF);
      fn_out[0] = 1'b0;
      at_neg();
      chk("R6 txd low", 32'({pad_oe[7:6], pad_out[7:6]}), 32'hC);

      // bus functions and single-chip overrides
      cur_req = "R7";
      wr(0, 8); wr(1, 9); wr(2, 10); wr(3, 11); wr(4, 5); wr(5, 6);
      data_oe = 1'b1;
      fn_out = 5'b00110;
      pad_in[5:4] = 2'b00;
      at_neg();
      chk("R7 normal oe", 32'(pad_oe[3:0]), 32'hF);
      chk("R7 normal out", 32'(pad_out[3:0]), 32'h3);
      chk("R4 wait breq low", 32'(fn_in[5:4]), 0);
      single_chip = 1'b1;
      at_neg();
      chk("R7 single oe", 32'(pad_oe[3:0]), 32'hD);
      chk("R7 single out", 32'(pad_out[3:0] & 4'hD), 32'hC);
      chk("R8 bus inputs idle", 32'(fn_in[5:4]), 32'h3);
      single_chip = 1'b0;
      at_neg();
      chk("R8 released", 32'(fn_in[5:4]), 0);

      // undefined codes
      cur_req = "R9";
      wr(6, 13); wr(7, 15); wr(8, 8'hC0);
      pad_in[7:6] = 2'b01;
      at_neg();
      chk("R9 no drive", 32'(pad_oe[7:6]), 0);
      chk("R9 port read", 32'(port_rd[7:6]), 32'h1);
      chk("R9 no merge", 32'(fn_in[1:0]), 0);
      pad_in[7:6] = 2'b10;
      at_neg();
      chk("R9 port read flip", 32'(port_rd[7:6]), 32'h2);

      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule